// File: doc/BRIEF.md
# Paged External Data RAM

This block is a 512-byte data RAM placed in the 64 KB external data address space of a small 8-bit controller. The CPU reaches it in one of two ways. In pointer mode it presents a full 16-bit address; the RAM decodes only the low nine bits, so the same 512 bytes repeat every 0x200 bytes across the whole space. A linear fill can therefore run past the end of the RAM without resetting its pointer.

In indirect mode the CPU supplies only an 8-bit offset. The ninth address bit then comes from a one-bit page select. That bit lives in a control register on the special-function-register (SFR) bus at address 0xAA. The register's upper seven bits are fixed at zero.

Reads are registered and return data on the cycle after the access strobe. Writes store on the strobe edge. Reset clears the page select but leaves the RAM contents alone.

Top module: `xram_paged_top`

## Requirements
- R1: In pointer mode (`acc_mode` = 0) the RAM location is `acc_addr[8:0]`, and `acc_addr[15:9]` has no effect. For example, 0x0005, 0x0205 and 0x8405 all reach the same byte.
- R2: In indirect mode (`acc_mode` = 1) the location is {page_select, `acc_addr[7:0]`}, and `acc_addr[15:8]` has no effect. Page 0 reaches 0x000–0x0FF and page 1 reaches 0x100–0x1FF.
- R3: The page register answers at SFR address 0xAA and resets to 0x00. A read at 0xAA returns {7'b0, page_select}. A read at any other SFR address returns 0x00, and a write there leaves the page select unchanged.
- R4: Only bit 0 of the page register can be written. Bits 7..1 always read as 0, whatever value was written to them.
- R5: A page register write takes effect from the next cycle. An indirect access in the same cycle as that write still uses the old page.
- R6: A read (`acc_en` = 1, `acc_wr` = 0) presents the addressed byte on `acc_rdata` one cycle after the strobe. `acc_rdata` then holds its value until the next read.
- R7: A write (`acc_en` = 1, `acc_wr` = 1) stores `acc_wdata` at the addressed location and leaves `acc_rdata` unchanged.
- R8: Reset clears the page select only. Bytes stored before a reset read back unchanged after it.
- R9: Reading the page register has no side effect on the page select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 1 | 0 = 16-bit pointer, 1 = 8-bit indirect |
| acc_addr | input | 16 | Access address (low byte only in indirect mode) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid one cycle after a read |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |

## Verification
The assertions check several rules on every cycle. The upper page-register bits always read zero. The page select changes only on the cycle after a write to 0xAA, and it updates to the written bit 0. Every indirect access indexes the page the register held in that cycle. Read data stays steady unless a read was issued.

Other behaviour can only be shown by the bench scenarios, which track RAM contents against a model. These cover aliasing across the 64 KB space, the split between the two pages, and the ordering when a page write and an access fall in the same cycle. They also show that stored bytes survive a reset.

// File: rtl/xram_pkg.sv
package xram_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_PTR16 = 1'b0,
        MODE_IND8  = 1'b1
    } acc_mode_e;
endpackage

// File: rtl/xram_page_reg.sv
module xram_page_reg #(
    parameter int          PAGE_W   = 1,
    parameter logic [7:0]  SFR_ADDR = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output logic [PAGE_W-1:0] page_sel
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } state_t;

    state_t st_d, st_q;
    logic   hit;

    always_comb begin
        hit  = (sfr_addr == SFR_ADDR);
        st_d = st_q;
        if (sfr_wr && hit) begin
            st_d.page = sfr_wdata[PAGE_W-1:0];
        end
        sfr_rdata = hit ? {{(8-PAGE_W){1'b0}}, st_q.page} : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_sel = st_q.page;
endmodule

// File: rtl/xram_addr_map.sv
module xram_addr_map #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 9,
    parameter int PAGE_W = 1
) (
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [IDX_W-1:0]  idx
);
    import xram_pkg::*;

    always_comb begin
        if (acc_mode_e'(mode) == MODE_IND8) begin
            idx = {page_sel, addr[7:0]};
        end else begin
            idx = addr[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/xram_array.sv
module xram_array #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } state_t;

    logic [DATA_W-1:0] mem [DEPTH];
    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en && !wr) begin
            st_d.rdata = mem[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (en && wr) begin
            mem[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/xram_paged_top.sv
module xram_paged_top #(
    parameter int          RAM_DEPTH = 512,
    parameter int          ADDR_W    = 16,
    parameter logic [7:0]  PAGE_SFR  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_mode,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata
);
    localparam int IDX_W  = $clog2(RAM_DEPTH);
    localparam int PAGE_W = IDX_W - 8;

    logic [PAGE_W-1:0] page_sel;
    logic [IDX_W-1:0]  ram_idx;

    xram_page_reg #(.PAGE_W(PAGE_W), .SFR_ADDR(PAGE_SFR)) u_page (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .page_sel(page_sel)
    );

    xram_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_map (
        .mode(acc_mode), .addr(acc_addr), .page_sel(page_sel), .idx(ram_idx)
    );

    xram_array #(.DEPTH(RAM_DEPTH), .DATA_W(8)) u_ram (
        .clk(clk), .rst_n(rst_n), .en(acc_en), .wr(acc_wr), .idx(ram_idx),
        .wdata(acc_wdata), .rdata(acc_rdata)
    );
endmodule

// File: rtl/xram_paged_chk.sv
module xram_paged_chk #(
    parameter int         IDX_W    = 9,
    parameter int         PAGE_W   = 1,
    parameter logic [7:0] PAGE_SFR = 8'hAA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic              acc_mode,
    input logic [15:0]       acc_addr,
    input logic [7:0]        acc_rdata,
    input logic [7:0]        sfr_addr,
    input logic              sfr_wr,
    input logic [7:0]        sfr_wdata,
    input logic [7:0]        sfr_rdata,
    input logic [PAGE_W-1:0] page_sel,
    input logic [IDX_W-1:0]  ram_idx
);
    // R4: upper register bits always read zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == PAGE_SFR) |-> (sfr_rdata[7:PAGE_W] == '0));

    // R5: page write lands on the next cycle with the written value
    a_r5_page_next: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == PAGE_SFR) |=> (page_sel == $past(sfr_wdata[PAGE_W-1:0])));

    // R9: without a page write the page select holds
    a_r9_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_wr && sfr_addr == PAGE_SFR) |=> $stable(page_sel));

    // R2: indirect access indexes the current page
    a_r2_ind_page: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode) |-> (ram_idx[IDX_W-1:8] == page_sel && ram_idx[7:0] == acc_addr[7:0]));

    // R6: read data changes only after a read
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> $stable(acc_rdata));
endmodule

bind xram_paged_top xram_paged_chk #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .PAGE_SFR(PAGE_SFR)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_mode(acc_mode),
    .acc_addr(acc_addr), .acc_rdata(acc_rdata), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .page_sel(page_sel), .ram_idx(ram_idx)
);

// File: tb/xram_paged_top_test.sv
module xram_paged_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_mode = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] model [512];
    logic       mpage = 1'b0;
    logic       chk_pending = 1'b0;
    logic [7:0] last_read = '0;

    always #5 clk = ~clk;

    xram_paged_top uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_mode(acc_mode),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    function automatic logic [8:0] idx_of(logic mode, logic [15:0] a, logic pg);
        return mode ? {pg, a[7:0]} : a[8:0];
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        acc_en = 1'b0; acc_wr = 1'b0; sfr_wr = 1'b0;
    endtask

    task automatic mem_wr(logic mode, logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_mode = mode; acc_addr = a; acc_wdata = d;
        model[idx_of(mode, a, mpage)] = d;
        idle();
    endtask

    task automatic mem_rd(logic mode, logic [15:0] a, string tag);
        item_t it;
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_mode = mode; acc_addr = a;
        it.exp = model[idx_of(mode, a, mpage)];
        it.tag = tag;
        last_read = it.exp;
        sb_q.push_back(it);
        idle();
    endtask

    task automatic sfr_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wr = 1'b1; sfr_wdata = d;
        if (a == 8'hAA) mpage = d[0];
        idle();
    endtask

    task automatic sfr_check(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        sfr_addr = a;
        #1;
        check(tag, sfr_rdata, exp);
    endtask

    // monitor: a read issued on a clock edge is compared at the following negedge
    always @(posedge clk) chk_pending <= rst_n && acc_en && !acc_wr;

    always @(negedge clk) begin
        if (chk_pending) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R6: actual %02h expected none (empty scoreboard)", acc_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, acc_rdata, it.exp);
            end
        end
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        sfr_check(8'hAA, 8'h00, "R3 reset value");
        sfr_check(8'h55, 8'h00, "R3 other address reads zero");

        // R1: aliasing in pointer mode
        mem_wr(1'b0, 16'h0005, 8'h3C);
        mem_rd(1'b0, 16'h0205, "R1 alias 0x0205");
        mem_rd(1'b0, 16'h8405, "R1 alias 0x8405");
        for (int i = 0; i < 512; i++) mem_wr(1'b0, 16'(i), 8'(i * 7 + 1));
        for (int i = 0; i < 512; i += 37) mem_rd(1'b0, 16'hFE00 + 16'(i), "R1 fill via high alias");
        mem_wr(1'b0, 16'hC1FF, 8'hA5);
        mem_rd(1'b0, 16'h01FF, "R1 top byte through alias");

        // R2: indirect mode, page 0 and page 1
        mem_wr(1'b1, 16'hFF10, 8'h11);
        mem_rd(1'b0, 16'h0010, "R2 page0 lands at 0x010");
        sfr_write(8'hAA, 8'h01);
        sfr_check(8'hAA, 8'h01, "R3 page readback");
        mem_wr(1'b1, 16'h0010, 8'h22);
        mem_rd(1'b0, 16'h0110, "R2 page1 lands at 0x110");
        mem_rd(1'b1, 16'h7710, "R2 upper operand byte ignored");
        mem_rd(1'b0, 16'h0010, "R2 page0 byte untouched");

        // R4: only bit 0 writable
        sfr_write(8'hAA, 8'hFE);
        sfr_check(8'hAA, 8'h00, "R4 write FE reads 00");
        sfr_write(8'hAA, 8'hFF);
        sfr_check(8'hAA, 8'h01, "R4 write FF reads 01");

        // R3: write elsewhere ignored
        sfr_write(8'hAB, 8'h00);
        sfr_check(8'hAA, 8'h01, "R3 other address write ignored");

        // R9: repeated reads leave page alone
        sfr_check(8'hAA, 8'h01, "R9 read again");
        mem_rd(1'b1, 16'h0010, "R9 page still 1 after reads");

        // R5: same-cycle page write and access uses old page
        @(negedge clk);
        begin
            item_t it;
            sfr_addr = 8'hAA; sfr_wr = 1'b1; sfr_wdata = 8'h00;
            acc_en = 1'b1; acc_wr = 1'b0; acc_mode = 1'b1; acc_addr = 16'h0010;
            it.exp = model[idx_of(1'b1, 16'h0010, mpage)];
            it.tag = "R5 same-cycle uses old page";
            last_read = it.exp;
            sb_q.push_back(it);
            mpage = 1'b0;
            idle();
        end
        mem_rd(1'b1, 16'h0010, "R5 next access uses new page");

        // R6/R7: rdata holds over idle and write cycles
        mem_wr(1'b0, 16'h0033, 8'h99);
        @(negedge clk);
        check("R7 write leaves rdata", acc_rdata, last_read);
        @(negedge clk);
        check("R6 rdata holds while idle", acc_rdata, last_read);

        // R8: reset clears page but not RAM
        sfr_write(8'hAA, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mpage = 1'b0;
        sfr_check(8'hAA, 8'h00, "R8 page cleared by reset");
        mem_rd(1'b0, 16'h0033, "R8 RAM kept over reset");
        mem_rd(1'b0, 16'h0110, "R8 page1 byte kept over reset");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R6: actual %0d pending expected 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule